// File: doc/BRIEF.md
# Serial Addressed Control Latch Bank

This block takes a three-wire serial control stream (bit clock, data and strobe) and turns it into a bank of individually addressable control bits. A host shifts in a seven-bit frame: a six-bit address with its most significant bit first, then a single value bit. When the strobe rises, only the one latch named by the address is written. It is set to the value bit, and every other latch keeps its state. One reserved address, zero, wipes the whole bank instead.

The latched bits drive the switch enables of an audio cross-point matrix and a handful of control flags. These flags cover amplifier enables, receiver volume steps and mutes. The three serial pins are asynchronous to the system clock. Each pin passes through a synchronizer, and edges are found in the system clock domain, which must run at least eight times faster than the serial clock. Besides the raw 64-bit vector, the block offers two decoded outputs: a receiver-volume step code and a receiver noise-reduction enable.

Top module: `serial_ctl_bank`

## Requirements
- R1: While rst_n is low all latch bits, rx_vol_o and nr_en_o are 0, and they remain 0 after release until a strobe is received.
- R2: A frame is the last seven data values sampled on synchronized rising edges of ser_clk_i: the first six form the address with the most significant bit first, and the seventh is the value bit.
- R3: While ser_stb_i stays low, serial clock edges shift data and no output changes.
- R4: A synchronized rising edge of ser_stb_i with a nonzero address and value 1 sets ctl_o[address], leaving every other bit unchanged. The new value appears three system cycles after the strobe pin rises.
- R5: The same strobe with value 0 clears ctl_o[address] and leaves every other bit unchanged.
- R6: A strobe with address 0 clears all 64 bits whatever the value bit is. ctl_o[0] always reads 0.
- R7: rx_vol_o is 2'b10 (+9 dB step) whenever bit 0x1F is set, 2'b01 (+6 dB step) when bit 0x17 is set and 0x1F is clear, and 2'b00 otherwise.
- R8: nr_en_o is 1 exactly when at least one of bits 0x09, 0x21 and 0x29 is set.
- R9: A strobe rising edge that reaches the system domain in the same cycle as a serial clock rising edge uses the frame that includes the bit shifted on that edge.
- R10: When more than seven bits are shifted before a strobe, only the last seven count.
- R11: Only the rising edge of the strobe writes. Clock edges while the strobe stays high, and the falling edge of the strobe, change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| ser_clk_i | input | 1 | Serial bit clock, asynchronous |
| ser_dat_i | input | 1 | Serial data, asynchronous |
| ser_stb_i | input | 1 | Serial strobe, asynchronous |
| ctl_o | output | 64 | Latched control bits, index equals address |
| rx_vol_o | output | 2 | Receiver volume step: 00 none, 01 +6 dB, 10 +9 dB |
| nr_en_o | output | 1 | Receiver noise-reduction enable |

## Verification
The assertions assume that each serial pin holds a level for several system cycles, longer than the synchronizer depth plus one. They also assume that data is steady when the serial clock rises, so that every pin transition yields exactly one synchronized edge. The stimulus holds each level for six system cycles and changes data only while the serial clock is low. The one deliberate exception is the case where the strobe and the final clock edge are raised at the same instant. A behavioural model in the bench tracks the pin history with the same three-cycle latency and is compared with all outputs on every cycle.

// File: rtl/serctl_pkg.sv
package serctl_pkg;

   typedef enum logic [1:0] {
      VOL_FLAT = 2'b00,
      VOL_UP6  = 2'b01,
      VOL_UP9  = 2'b10
   } vol_code_e;

   typedef enum logic {
      SYNC_LEVEL = 1'b0,
      SYNC_RISE  = 1'b1
   } sync_mode_e;

endpackage

// File: rtl/serctl_pin_sync.sv
module serctl_pin_sync
   import serctl_pkg::*;
#(
   parameter int         STAGES = 2,
   parameter sync_mode_e MODE   = SYNC_RISE
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic sig_o
);

   localparam int DEPTH = STAGES + 1;

   logic [DEPTH-1:0] stg_q;

   if (STAGES < 2) begin : g_bad_stages
      $error("serctl_pin_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_q <= '0;
      end else begin
         stg_q <= {stg_q[DEPTH-2:0], pin_i};
      end
   end

   if (MODE == SYNC_RISE) begin : g_rise
      assign sig_o = stg_q[STAGES-1] & ~stg_q[STAGES];

      // R2: a synchronized edge lasts exactly one system cycle
      a_r2_single_pulse : assert property (@(posedge clk) disable iff (!rst_n)
         sig_o |=> !sig_o);
   end else begin : g_level
      assign sig_o = stg_q[STAGES-1];
      logic unused_tail;
      assign unused_tail = stg_q[STAGES];
   end

endmodule

// File: rtl/serctl_shreg.sv
module serctl_shreg #(
   parameter int FRAME_W = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               shift_i,
   input  logic               bit_i,
   output logic [FRAME_W-1:0] frame_nxt_o
);

   logic [FRAME_W-1:0] frame_q;

   if (FRAME_W < 2) begin : g_bad_width
      $error("serctl_shreg: FRAME_W must be at least 2");
   end

   // shifted value is visible in the same cycle so a coincident strobe sees it
   always_comb begin
      frame_nxt_o = frame_q;
      if (shift_i) begin
         frame_nxt_o = {frame_q[FRAME_W-2:0], bit_i};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_q <= '0;
      end else begin
         frame_q <= frame_nxt_o;
      end
   end

   // R3: the register moves only on a synchronized serial clock edge
   a_r3_shift_only_on_edge : assert property (@(posedge clk) disable iff (!rst_n)
      !shift_i |=> $stable(frame_q));

endmodule

// File: rtl/serctl_latches.sv
module serctl_latches #(
   parameter int ADDR_W = 6
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  upd_i,
   input  logic [ADDR_W-1:0]     addr_i,
   input  logic                  val_i,
   output logic [(1<<ADDR_W)-1:0] lat_o
);

   localparam int NUM_LAT = 1 << ADDR_W;

   logic clr_all;
   assign clr_all = upd_i && (addr_i == '0);

   for (genvar g = 0; g < NUM_LAT; g++) begin : g_bit
      if (g == 0) begin : g_reserved
         assign lat_o[g] = 1'b0;
      end else begin : g_cell
         logic cell_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cell_q <= 1'b0;
            end else if (clr_all) begin
               cell_q <= 1'b0;
            end else if (upd_i && (addr_i == ADDR_W'(g))) begin
               cell_q <= val_i;
            end
         end
         assign lat_o[g] = cell_q;
      end
   end

   // R3: nothing moves without a strobe edge
   a_r3_hold_without_strobe : assert property (@(posedge clk) disable iff (!rst_n)
      !upd_i |=> $stable(lat_o));

   // R4: a nonzero address touches at most one bit
   a_r4_single_bit_write : assert property (@(posedge clk) disable iff (!rst_n)
      (upd_i && addr_i != '0) |=> ($countones(lat_o ^ $past(lat_o)) <= 1));

   // R6: address zero empties the bank
   a_r6_clear_all : assert property (@(posedge clk) disable iff (!rst_n)
      clr_all |=> (lat_o == '0));

   // R6: reserved bit never reads 1
   a_r6_bit0_zero : assert property (@(posedge clk) disable iff (!rst_n)
      lat_o[0] == 1'b0);

endmodule

// File: rtl/serctl_decode.sv
module serctl_decode
   import serctl_pkg::*;
#(
   parameter int                      ADDR_W    = 6,
   parameter logic [ADDR_W-1:0]       VOL6_ADDR = 6'h17,
   parameter logic [ADDR_W-1:0]       VOL9_ADDR = 6'h1F,
   parameter int                      NR_CNT    = 3,
   parameter logic [NR_CNT*ADDR_W-1:0] NR_LIST  = {6'h29, 6'h21, 6'h09}
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [(1<<ADDR_W)-1:0] lat_i,
   output vol_code_e              vol_o,
   output logic                   nr_o
);

   logic [NR_CNT-1:0] nr_hit;

   for (genvar k = 0; k < NR_CNT; k++) begin : g_nr
      assign nr_hit[k] = lat_i[NR_LIST[k*ADDR_W +: ADDR_W]];
   end

   assign nr_o = |nr_hit;

   always_comb begin
      if (lat_i[VOL9_ADDR]) begin
         vol_o = VOL_UP9;
      end else if (lat_i[VOL6_ADDR]) begin
         vol_o = VOL_UP6;
      end else begin
         vol_o = VOL_FLAT;
      end
   end

   // R7: the volume code is never the unused encoding
   a_r7_vol_legal : assert property (@(posedge clk) disable iff (!rst_n)
      vol_o != 2'b11);

   // R8: with every listed latch clear the enable is low
   a_r8_nr_needs_source : assert property (@(posedge clk) disable iff (!rst_n)
      (nr_hit == '0) |-> !nr_o);

endmodule

// File: rtl/serial_ctl_bank.sv
module serial_ctl_bank
   import serctl_pkg::*;
#(
   parameter int ADDR_W      = 6,
   parameter int SYNC_STAGES = 2,
   parameter logic [ADDR_W-1:0] VOL6_ADDR = 6'h17,
   parameter logic [ADDR_W-1:0] VOL9_ADDR = 6'h1F,
   parameter int NR_CNT      = 3,
   parameter logic [NR_CNT*ADDR_W-1:0] NR_LIST = {6'h29, 6'h21, 6'h09}
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    ser_clk_i,
   input  logic                    ser_dat_i,
   input  logic                    ser_stb_i,
   output logic [(1<<ADDR_W)-1:0]  ctl_o,
   output logic [1:0]              rx_vol_o,
   output logic                    nr_en_o
);

   localparam int FRAME_W = ADDR_W + 1;

   if (ADDR_W < 2 || ADDR_W > 8) begin : g_bad_addr_w
      $error("serial_ctl_bank: ADDR_W must lie in 2..8");
   end
   if (VOL6_ADDR == '0 || VOL9_ADDR == '0) begin : g_bad_vol_addr
      $error("serial_ctl_bank: volume addresses must be nonzero");
   end

   logic               clk_rise;
   logic               stb_rise;
   logic               dat_lvl;
   logic [FRAME_W-1:0] frame_nxt;
   vol_code_e          vol_code;

   serctl_pin_sync #(.STAGES(SYNC_STAGES), .MODE(SYNC_RISE)) u_sync_clk (
      .clk(clk), .rst_n(rst_n), .pin_i(ser_clk_i), .sig_o(clk_rise));

   serctl_pin_sync #(.STAGES(SYNC_STAGES), .MODE(SYNC_RISE)) u_sync_stb (
      .clk(clk), .rst_n(rst_n), .pin_i(ser_stb_i), .sig_o(stb_rise));

   serctl_pin_sync #(.STAGES(SYNC_STAGES), .MODE(SYNC_LEVEL)) u_sync_dat (
      .clk(clk), .rst_n(rst_n), .pin_i(ser_dat_i), .sig_o(dat_lvl));

   serctl_shreg #(.FRAME_W(FRAME_W)) u_shreg (
      .clk(clk), .rst_n(rst_n), .shift_i(clk_rise), .bit_i(dat_lvl),
      .frame_nxt_o(frame_nxt));

   serctl_latches #(.ADDR_W(ADDR_W)) u_latches (
      .clk(clk), .rst_n(rst_n), .upd_i(stb_rise),
      .addr_i(frame_nxt[FRAME_W-1:1]), .val_i(frame_nxt[0]),
      .lat_o(ctl_o));

   serctl_decode #(
      .ADDR_W(ADDR_W), .VOL6_ADDR(VOL6_ADDR), .VOL9_ADDR(VOL9_ADDR),
      .NR_CNT(NR_CNT), .NR_LIST(NR_LIST)
   ) u_decode (
      .clk(clk), .rst_n(rst_n), .lat_i(ctl_o), .vol_o(vol_code), .nr_o(nr_en_o));

   assign rx_vol_o = vol_code;

   // R9: coincident strobe and clock edges write the just-shifted value bit
   a_r9_coincident_bit : assert property (@(posedge clk) disable iff (!rst_n)
      (clk_rise && stb_rise && frame_nxt[FRAME_W-1:1] != '0)
         |=> (ctl_o[$past(frame_nxt[FRAME_W-1:1])] == $past(dat_lvl)));

endmodule

// File: tb/test_serial_ctl_bank.sv
module test_serial_ctl_bank;

   localparam int HOLD = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        p_clk = 1'b0;
   logic        p_dat = 1'b0;
   logic        p_stb = 1'b0;
   logic [63:0] ctl_o;
   logic [1:0]  rx_vol_o;
   logic        nr_en_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   logic [63:0] exp_lat = '0;

   // behavioural reference
   bit   [2:0]  h_clk, h_stb, h_dat;
   logic [6:0]  m_sr  = '0;
   logic [63:0] m_lat = '0;

   always #5 clk = ~clk;

   serial_ctl_bank i_serial_ctl_bank (
      .clk(clk), .rst_n(rst_n), .ser_clk_i(p_clk), .ser_dat_i(p_dat),
      .ser_stb_i(p_stb), .ctl_o(ctl_o), .rx_vol_o(rx_vol_o), .nr_en_o(nr_en_o));

   always @(posedge clk) begin
      if (!rst_n) begin
         h_clk = '0; h_stb = '0; h_dat = '0;
         m_sr  = '0; m_lat = '0;
      end else begin
         if (h_clk[1] && !h_clk[2]) m_sr = {m_sr[5:0], h_dat[1]};
         if (h_stb[1] && !h_stb[2]) begin
            if (m_sr[6:1] == 6'd0) m_lat = '0;
            else m_lat[m_sr[6:1]] = m_sr[0];
         end
         h_clk = {h_clk[1:0], p_clk};
         h_stb = {h_stb[1:0], p_stb};
         h_dat = {h_dat[1:0], p_dat};
      end
   end

   function automatic logic [1:0] m_vol(input logic [63:0] l);
      if (l[31]) return 2'b10;
      if (l[23]) return 2'b01;
      return 2'b00;
   endfunction

   // cycle compare (R1, R4, R5, R6, R7, R8 timing)
   always @(negedge clk) begin
      if (!done) begin
         n_chk++;
         if (ctl_o !== m_lat || rx_vol_o !== m_vol(m_lat) ||
             nr_en_o !== (m_lat[9] | m_lat[33] | m_lat[41])) begin
            n_bad++;
            $display("FAIL R4 cycle model t=%0t ctl=%h vol=%b nr=%b expected ctl=%h vol=%b nr=%b",
                     $time, ctl_o, rx_vol_o, nr_en_o, m_lat, m_vol(m_lat),
                     m_lat[9] | m_lat[33] | m_lat[41]);
         end
      end
   end

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic shift_bit(input logic b);
      p_clk = 1'b0; p_dat = b; wait_n(HOLD);
      p_clk = 1'b1; wait_n(HOLD);
   endtask

   task automatic pulse_stb;
      p_stb = 1'b1; wait_n(HOLD);
      p_stb = 1'b0; wait_n(HOLD);
   endtask

   task automatic shift_frame(input logic [5:0] a, input logic d);
      for (int i = 5; i >= 0; i--) shift_bit(a[i]);
      shift_bit(d);
   endtask

   task automatic note(input logic [5:0] a, input logic d);
      if (a == 6'd0) exp_lat = '0;
      else exp_lat[a] = d;
   endtask

   task automatic send(input logic [5:0] a, input logic d);
      shift_frame(a, d);
      pulse_stb;
      note(a, d);
   endtask

   initial begin
      repeat (HOLD * 120000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      wait_n(4);
      rst_n = 1'b1;
      wait_n(4);
      check("R1 reset ctl", ctl_o, 64'd0);
      check("R1 reset vol/nr", {61'd0, rx_vol_o, nr_en_o}, 64'd0);

      send(6'h07, 1'b1);
      check("R4 set 0x07", ctl_o, exp_lat);
      send(6'h30, 1'b1);
      check("R2 msb-first 0x30 set, 0x03 clear", {62'd0, ctl_o[48], ctl_o[3]}, 64'd2);

      send(6'h17, 1'b1);
      check("R7 vol +6", {62'd0, rx_vol_o}, 64'd1);
      send(6'h1F, 1'b1);
      check("R7 vol +9 priority", {62'd0, rx_vol_o}, 64'd2);
      send(6'h1F, 1'b0);
      check("R5 clear 0x1F", ctl_o, exp_lat);
      check("R7 vol back to +6", {62'd0, rx_vol_o}, 64'd1);

      send(6'h21, 1'b1);
      check("R8 nr via 0x21", {63'd0, nr_en_o}, 64'd1);
      send(6'h21, 1'b0);
      check("R8 nr off", {63'd0, nr_en_o}, 64'd0);
      send(6'h29, 1'b1);
      check("R8 nr via 0x29", {63'd0, nr_en_o}, 64'd1);

      shift_frame(6'h3F, 1'b1);
      check("R3 no change without strobe", ctl_o, exp_lat);
      pulse_stb;
      note(6'h3F, 1'b1);
      check("R4 set 0x3F after strobe", ctl_o, exp_lat);

      send(6'h00, 1'b1);
      check("R6 address 0 clears all", ctl_o, 64'd0);

      // R9: strobe raised together with final clock edge
      for (int i = 5; i >= 0; i--) shift_bit(1'(6'h0F >> i));
      p_clk = 1'b0; p_dat = 1'b1; wait_n(HOLD);
      p_clk = 1'b1; p_stb = 1'b1; wait_n(HOLD);
      p_stb = 1'b0; wait_n(HOLD);
      note(6'h0F, 1'b1);
      check("R9 coincident strobe uses last bit", ctl_o, exp_lat);

      // R10: two extra leading bits
      shift_bit(1'b1); shift_bit(1'b1);
      send(6'h09, 1'b1);
      check("R10 last seven bits only", ctl_o, exp_lat);

      // R11: strobe held high while shifting another frame
      shift_frame(6'h27, 1'b1);
      p_stb = 1'b1; wait_n(HOLD);
      note(6'h27, 1'b1);
      shift_frame(6'h2F, 1'b1);
      check("R11 no write while strobe high", ctl_o, exp_lat);
      p_stb = 1'b0; wait_n(HOLD);
      check("R11 no write on strobe fall", ctl_o, exp_lat);
      check("R6 bit 0 reads 0", {63'd0, ctl_o[0]}, 64'd0);

      wait_n(2);
      rst_n = 1'b0;
      wait_n(3);
      check("R1 reset clears bank", ctl_o, 64'd0);
      rst_n = 1'b1;
      wait_n(3);
      exp_lat = '0;
      send(6'h0F, 1'b1);
      check("R4 write after reset", ctl_o, exp_lat);

      wait_n(4);
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule